// File: doc/BRIEF.md
# TLP Payload Realigner

This block sits behind a 64-bit streaming receive port that delivers transaction-layer packets as two-dword beats. Each incoming beat brings a data word, per-byte enables, start and end flags and an eight-bit BAR-hit vector. The two header beats of a packet are split off and shown as one 128-bit header with a single-cycle valid pulse. The payload that follows goes out as packed 64-bit beats with byte enables and a last flag. Downstream can stall the payload with a ready input.

If the request address has bit 2 set, the first payload dword arrives in the upper half of its beat and the lower half is a filler dword. The block drops that filler and moves every later dword down by one lane. Output beat k then holds payload dwords 2k and 2k+1, so the first dword is always in the low lane. When this shift leaves one dword in the upper half of the last input beat, one extra flush beat is sent.

Upstream may go on sending for up to three cycles after the block lowers its ready output. Every beat that arrives is written into an internal buffer. Ready stays high only while the buffer has room for those late beats.

Top module: `tlp_payload_aligner`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0 and `hdrValid` is 0.
- R2: Every beat presented with `inValid` high is stored, whatever the level of `inReady`. `inReady` is high only when more than `LATE_BEATS` (3) buffer entries are free. With the default buffer of 6 entries, an upstream that keeps sending for up to three cycles after `inReady` falls loses no beat. A sender that stops at once when `inReady` is 0 also loses no beat.
- R3: The first header beat of a packet (start flag set) carries header dword 0 in bits 31:0 and dword 1 in bits 63:32. The next beat carries dword 2 low and dword 3 high. `hdrData` shows {dw3, dw2, dw1, dw0}, with dw0 in bits 31:0. `hdrValid` is high for exactly one cycle per packet: the cycle after the second header beat leaves the buffer.
- R4: If bit 29 of dword 0 is set (4-dword header), the address lane bit is bit 2 of dword 3. Otherwise it is bit 2 of dword 2. Payload always starts on the beat after the two header beats.
- R5: If the address lane bit is 0, each payload beat is passed on unchanged: data, byte enables, and `outLast` equal to the end flag.
- R6: If the address lane bit is 1, the lower half of the first payload beat is dropped. Output beat k carries payload dword 2k in bits 31:0 and dword 2k+1 in bits 63:32. `outBe[3:0]` qualifies bits 31:0 and `outBe[7:4]` qualifies bits 63:32, and each group of enables moves with its own dword.
- R7: A shifted packet with an odd dword count ends on a beat whose upper dword has `outBe[7:4]` = 0 and `outLast` = 1. If the final input beat still has data in its upper half, one extra flush beat carries that dword.
- R8: `hdrBar` is the BAR-hit vector of the start beat. From the header pulse until the last payload beat is accepted, `hdrBar` does not change.
- R9: While `outValid` is 1 and `outReady` is 0, `outData`, `outBe` and `outLast` do not change.
- R10: A packet whose second header beat has the end flag set produces only the header pulse and no payload beat.
- R11: A beat without the start flag that arrives while a header is awaited is dropped. It produces neither a header nor a payload beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming beat present |
| inReady | output | 1 | Permission for upstream to keep sending |
| inData | input | 64 | Incoming beat data |
| inSop | input | 1 | First header beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| inBe | input | 8 | Byte enables, bit i qualifies byte i |
| inBar | input | 8 | BAR-hit vector, meaningful with `inSop` |
| hdrValid | output | 1 | One-cycle header pulse |
| hdrData | output | 128 | Header dwords {dw3, dw2, dw1, dw0} |
| hdrBar | output | 8 | BAR-hit vector of the current packet |
| outValid | output | 1 | Payload beat present |
| outReady | input | 1 | Downstream accepts the payload beat |
| outData | output | 64 | Packed payload data |
| outBe | output | 8 | Payload byte enables |
| outLast | output | 1 | Final payload beat of the packet |

## Verification
The hardest case to reach is a full buffer filled while upstream is still sending its late beats. This needs a long payload, a stalled output and a sender that sends for the whole three-cycle window after ready falls. The bench's sender tracks the last three samples of `inReady` and sends whenever any of them was high. A directed phase holds `outReady` low for a twelve-dword packet until all six buffer slots are full, then drains it and checks every dword. The main table also drives random output stalls and input gaps over both header formats, both lanes, odd and even payload lengths, a header-only packet and a stray beat.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  localparam int DW_W        = 32;
  localparam int BEAT_W      = 2 * DW_W;
  localparam int BE_W        = BEAT_W / 8;
  localparam int LANE_BE_W   = BE_W / 2;
  localparam int BAR_W       = 8;
  localparam int HDR_W       = 4 * DW_W;
  localparam int FMT4_BIT    = 29;
  localparam int HASDATA_BIT = 30;
  localparam int LANE_BIT    = 2;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              sop;
    logic              eop;
    logic [BAR_W-1:0]  bar;
  } beat_t;

  typedef enum logic [1:0] {
    OM_PASS,
    OM_FIRSTHI,
    OM_MERGE,
    OM_FLUSH
  } outMode_e;

  typedef struct packed {
    logic     pop;
    logic     loadHdrA;
    logic     loadHdrB;
    logic     loadHold;
    logic     outValid;
    logic     outLast;
    outMode_e mode;
  } ctrlStrobe_t;
endpackage

// File: rtl/tpa_fifo.sv
module tpa_fifo import tpa_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int SLACK = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  beat_t            pushBeat,
  input  logic             pop,
  output beat_t            headBeat,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  output logic             ready
);
  beat_t            mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headBeat = mem[rdPtr];
  assign empty    = (count == '0);
  assign ready    = (CNT_W'(DEPTH) - count) > CNT_W'(SLACK);
endmodule

// File: rtl/tpa_ctrl.sv
module tpa_ctrl import tpa_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        headValid,
  input  logic        headSop,
  input  logic        headEop,
  input  logic        headHiUsed,
  input  logic        headLoLane,
  input  logic        headHiLane,
  input  logic        hdrIs4Dw,
  input  logic        outReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {S_HDR0, S_HDR1, S_PAY, S_FLUSH} state_e;

  state_e state, stateNx;
  logic   shiftOn, shiftNx;
  logic   firstPay, firstNx;

  always_comb begin
    strobe   = '0;
    strobe.mode = OM_PASS;
    stateNx  = state;
    shiftNx  = shiftOn;
    firstNx  = firstPay;
    unique case (state)
      S_HDR0: begin
        if (headValid) begin
          strobe.pop      = 1'b1;
          strobe.loadHdrA = headSop;
          if (headSop) stateNx = S_HDR1;
        end
      end
      S_HDR1: begin
        if (headValid) begin
          strobe.pop      = 1'b1;
          strobe.loadHdrB = 1'b1;
          if (headEop) begin
            stateNx = S_HDR0;
          end else begin
            stateNx = S_PAY;
            shiftNx = hdrIs4Dw ? headHiLane : headLoLane;
            firstNx = 1'b1;
          end
        end
      end
      S_PAY: begin
        if (!shiftOn) begin
          strobe.mode     = OM_PASS;
          strobe.outValid = headValid;
          strobe.outLast  = headEop;
          if (headValid && outReady) begin
            strobe.pop = 1'b1;
            if (headEop) stateNx = S_HDR0;
          end
        end else if (firstPay) begin
          strobe.mode = OM_FIRSTHI;
          if (headValid) begin
            if (headEop) begin
              strobe.outValid = 1'b1;
              strobe.outLast  = 1'b1;
              if (outReady) begin
                strobe.pop = 1'b1;
                stateNx    = S_HDR0;
              end
            end else begin
              strobe.pop      = 1'b1;
              strobe.loadHold = 1'b1;
              firstNx         = 1'b0;
            end
          end
        end else begin
          strobe.mode     = OM_MERGE;
          strobe.outValid = headValid;
          strobe.outLast  = headEop && !headHiUsed;
          if (headValid && outReady) begin
            strobe.pop      = 1'b1;
            strobe.loadHold = 1'b1;
            if (headEop) stateNx = headHiUsed ? S_FLUSH : S_HDR0;
          end
        end
      end
      S_FLUSH: begin
        strobe.mode     = OM_FLUSH;
        strobe.outValid = 1'b1;
        strobe.outLast  = 1'b1;
        if (outReady) stateNx = S_HDR0;
      end
      default: stateNx = S_HDR0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_HDR0;
      shiftOn  <= 1'b0;
      firstPay <= 1'b0;
    end else begin
      state    <= stateNx;
      shiftOn  <= shiftNx;
      firstPay <= firstNx;
    end
  end
endmodule

// File: rtl/tpa_dpath.sv
module tpa_dpath import tpa_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BEAT_W-1:0] headData,
  input  logic [BE_W-1:0]   headBe,
  input  logic [BAR_W-1:0]  headBar,
  output logic              hdrValid,
  output logic [HDR_W-1:0]  hdrData,
  output logic [BAR_W-1:0]  hdrBar,
  output logic              hdrIs4Dw,
  output logic [BEAT_W-1:0] outData,
  output logic [BE_W-1:0]   outBe
);
  logic [BEAT_W-1:0]    hdrLo, hdrHi;
  logic [DW_W-1:0]      holdDw;
  logic [LANE_BE_W-1:0] holdBe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrLo    <= '0;
      hdrHi    <= '0;
      hdrBar   <= '0;
      hdrValid <= 1'b0;
      holdDw   <= '0;
      holdBe   <= '0;
    end else begin
      hdrValid <= strobe.loadHdrB;
      if (strobe.loadHdrA) begin
        hdrLo  <= headData;
        hdrBar <= headBar;
      end
      if (strobe.loadHdrB) hdrHi <= headData;
      if (strobe.loadHold) begin
        holdDw <= headData[BEAT_W-1:DW_W];
        holdBe <= headBe[BE_W-1:LANE_BE_W];
      end
    end
  end

  assign hdrData  = {hdrHi, hdrLo};
  assign hdrIs4Dw = hdrLo[FMT4_BIT];

  always_comb begin
    unique case (strobe.mode)
      OM_FIRSTHI: begin
        outData = {{DW_W{1'b0}}, headData[BEAT_W-1:DW_W]};
        outBe   = {{LANE_BE_W{1'b0}}, headBe[BE_W-1:LANE_BE_W]};
      end
      OM_MERGE: begin
        outData = {headData[DW_W-1:0], holdDw};
        outBe   = {headBe[LANE_BE_W-1:0], holdBe};
      end
      OM_FLUSH: begin
        outData = {{DW_W{1'b0}}, holdDw};
        outBe   = {{LANE_BE_W{1'b0}}, holdBe};
      end
      default: begin
        outData = headData;
        outBe   = headBe;
      end
    endcase
  end
endmodule

// File: rtl/tlp_payload_aligner.sv
module tlp_payload_aligner import tpa_pkg::*; #(
  parameter int BUF_DEPTH  = 6,
  parameter int LATE_BEATS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BEAT_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [BE_W-1:0]   inBe,
  input  logic [BAR_W-1:0]  inBar,
  output logic              hdrValid,
  output logic [HDR_W-1:0]  hdrData,
  output logic [BAR_W-1:0]  hdrBar,
  output logic              outValid,
  input  logic              outReady,
  output logic [BEAT_W-1:0] outData,
  output logic [BE_W-1:0]   outBe,
  output logic              outLast
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  beat_t            inBeat, headBeat;
  logic             fifoEmpty, fifoPop;
  logic [CNT_W-1:0] fifoCount;
  ctrlStrobe_t      strobe;
  logic             hdrIs4Dw;

  assign inBeat  = '{data: inData, be: inBe, sop: inSop, eop: inEop, bar: inBar};
  assign fifoPop = strobe.pop;

  tpa_fifo #(.DEPTH(BUF_DEPTH), .SLACK(LATE_BEATS)) u_buf (
    .clk(clk), .rstN(rstN),
    .push(inValid), .pushBeat(inBeat),
    .pop(fifoPop), .headBeat(headBeat),
    .empty(fifoEmpty), .count(fifoCount), .ready(inReady)
  );

  tpa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .headValid(!fifoEmpty),
    .headSop(headBeat.sop),
    .headEop(headBeat.eop),
    .headHiUsed(|headBeat.be[BE_W-1:LANE_BE_W]),
    .headLoLane(headBeat.data[LANE_BIT]),
    .headHiLane(headBeat.data[DW_W+LANE_BIT]),
    .hdrIs4Dw(hdrIs4Dw),
    .outReady(outReady),
    .strobe(strobe)
  );

  tpa_dpath u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .headData(headBeat.data), .headBe(headBeat.be), .headBar(headBeat.bar),
    .hdrValid(hdrValid), .hdrData(hdrData), .hdrBar(hdrBar),
    .hdrIs4Dw(hdrIs4Dw),
    .outData(outData), .outBe(outBe)
  );

  assign outValid = strobe.outValid;
  assign outLast  = strobe.outLast;
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker import tpa_pkg::*; #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              fifoPop,
  input logic              hdrValid,
  input logic              hdrHasData,
  input logic [BAR_W-1:0]  hdrBar,
  input logic              outValid,
  input logic              outReady,
  input logic [BEAT_W-1:0] outData,
  input logic [BE_W-1:0]   outBe,
  input logic              outLast
);
  logic inPkt;

  always_ff @(posedge clk) begin
    if (!rstN) inPkt <= 1'b0;
    else       inPkt <= (inPkt || (hdrValid && hdrHasData)) && !(outValid && outReady && outLast);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fifoCount == CNT_W'(DEPTH)) |-> fifoPop);  // R2

  AST_HDR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> !hdrValid);  // R3

  AST_BAR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    inPkt |-> $stable(hdrBar));  // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outBe) && $stable(outLast)));  // R9

  AST_PAY_IN_PKT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inPkt || (hdrValid && hdrHasData)));  // R10
endmodule

bind tlp_payload_aligner tpa_checker #(.DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .fifoCount(fifoCount), .fifoPop(fifoPop),
  .hdrValid(hdrValid), .hdrHasData(hdrData[tpa_pkg::HASDATA_BIT]), .hdrBar(hdrBar),
  .outValid(outValid), .outReady(outReady),
  .outData(outData), .outBe(outBe), .outLast(outLast)
);

// File: tb/sim_tlp_payload_aligner.sv
module sim_tlp_payload_aligner;
  import tpa_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic        inSop = 1'b0;
  logic        inEop = 1'b0;
  logic [7:0]  inBe = '0;
  logic [7:0]  inBar = '0;
  logic        hdrValid;
  logic [127:0] hdrData;
  logic [7:0]  hdrBar;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outData;
  logic [7:0]  outBe;
  logic        outLast;

  always #4 clk = ~clk;

  tlp_payload_aligner u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSop(inSop), .inEop(inEop), .inBe(inBe), .inBar(inBar),
    .hdrValid(hdrValid), .hdrData(hdrData), .hdrBar(hdrBar),
    .outValid(outValid), .outReady(outReady),
    .outData(outData), .outBe(outBe), .outLast(outLast)
  );

  // Packet table: {stray, fmt4, lane, dword count[4:0], bar[7:0]}
  localparam logic [15:0] PKT_TAB [9] = '{
    {1'b0, 1'b1, 1'b0, 5'd4,  8'h01},
    {1'b0, 1'b1, 1'b1, 5'd1,  8'h02},
    {1'b0, 1'b1, 1'b1, 5'd4,  8'h04},
    {1'b0, 1'b1, 1'b1, 5'd3,  8'h08},
    {1'b1, 1'b0, 1'b0, 5'd2,  8'h10},
    {1'b0, 1'b0, 1'b1, 5'd2,  8'h20},
    {1'b0, 1'b1, 1'b0, 5'd0,  8'h40},
    {1'b0, 1'b0, 1'b0, 5'd5,  8'h80},
    {1'b0, 1'b0, 1'b1, 5'd6,  8'h81}
  };

  beat_t        txQ [$];
  logic [74:0]  expQ [$];   // {tag[1:0], data, be, last}
  logic [135:0] hdrQ [$];   // {bar, header}
  int checks = 0;
  int fails  = 0;
  logic [7:0] curBar = '0;
  bit   forceStall = 1'b0;
  bit   noGaps = 1'b0;
  logic [15:0] lfTx = 16'hACE1;
  logic [15:0] lfRx = 16'h1D2B;

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] payDw(input int p, input int i);
    return {8'(p), 8'(i), 16'hD00D};
  endfunction

  task automatic buildPkt(input int p, input logic [15:0] ent);
    bit stray, f4, sh;
    int n, nSlots, nBeats, nOut;
    logic [7:0]  bar;
    logic [31:0] dw0, dw1, dw2, dw3, adr;
    beat_t b;
    stray = ent[15]; f4 = ent[14]; sh = ent[13]; n = int'(ent[12:8]); bar = ent[7:0];
    if (stray) begin
      b = '{data: 64'hBAD0_BAD0_BAD0_BAD0, be: 8'hFF, sop: 1'b0, eop: 1'b1, bar: 8'hEE};
      txQ.push_back(b);
    end
    dw0 = {1'b0, (n != 0), f4, 19'h0, 10'(n)};
    dw1 = 32'hB000_0000 | 32'(p);
    adr = {25'h1000 + 25'(p), 4'h0, sh, (sh ? 2'b10 : 2'b00)};
    if (f4) begin dw2 = {29'h0, ~sh, 2'b00}; dw3 = adr; end
    else    begin dw2 = adr; dw3 = {29'h5, ~sh, 2'b00}; end
    b = '{data: {dw1, dw0}, be: 8'hFF, sop: 1'b1, eop: 1'b0, bar: bar};
    txQ.push_back(b);
    b = '{data: {dw3, dw2}, be: 8'hFF, sop: 1'b0, eop: (n == 0), bar: 8'h00};
    txQ.push_back(b);
    hdrQ.push_back({bar, dw3, dw2, dw1, dw0});
    nSlots = n + int'(sh);
    nBeats = (nSlots + 1) / 2;
    for (int k = 0; k < nBeats; k++) begin
      b = '{data: '0, be: '0, sop: 1'b0, eop: (k == nBeats - 1), bar: 8'h00};
      for (int l = 0; l < 2; l++) begin
        int i;
        i = 2 * k + l - int'(sh);
        if (i >= 0 && i < n) begin
          b.data[32*l +: 32] = payDw(p, i);
          b.be[4*l +: 4]     = (i == 0) ? (sh ? 4'hC : 4'hF) : 4'hF;
        end
      end
      txQ.push_back(b);
    end
    nOut = (n + 1) / 2;
    for (int k = 0; k < nOut; k++) begin
      logic [63:0] d;
      logic [7:0]  e;
      logic [1:0]  tag;
      d = '0; e = '0;
      for (int l = 0; l < 2; l++) begin
        int i;
        i = 2 * k + l;
        if (i < n) begin
          d[32*l +: 32] = payDw(p, i);
          e[4*l +: 4]   = (i == 0) ? (sh ? 4'hC : 4'hF) : 4'hF;
        end
      end
      tag = (k == nOut - 1) ? 2'd2 : (sh ? 2'd1 : 2'd0);
      expQ.push_back({tag, d, e, (k == nOut - 1)});
    end
  endtask

  // Sender: may keep sending for three cycles after inReady falls.
  initial begin
    bit h1, h2, h3, allowed;
    h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
    forever begin
      @(negedge clk);
      allowed = inReady || h1 || h2 || h3;
      h3 = h2; h2 = h1; h1 = inReady;
      lfTx = {lfTx[14:0], lfTx[15] ^ lfTx[13] ^ lfTx[12] ^ lfTx[10]};
      if (rstN && txQ.size() > 0 && allowed && (noGaps || lfTx[0] || lfTx[3])) begin
        beat_t b;
        b = txQ.pop_front();
        inValid = 1'b1; inData = b.data; inBe = b.be;
        inSop = b.sop; inEop = b.eop; inBar = b.bar;
      end else begin
        inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
      end
    end
  end

  // Receiver and checker of headers and payload beats.
  initial begin
    forever begin
      @(negedge clk);
      lfRx = {lfRx[14:0], lfRx[15] ^ lfRx[13] ^ lfRx[12] ^ lfRx[10]};
      outReady = !forceStall && (lfRx[0] || lfRx[5]);
      #1;
      if (rstN && hdrValid) begin
        if (hdrQ.size() == 0) chk(1'b0, "R3 R10 R11", "unexpected header", {8'h0, hdrData}, '0);
        else begin
          logic [135:0] eh;
          eh = hdrQ.pop_front();
          curBar = eh[135:128];
          chk({hdrBar, hdrData} == eh, "R3 R4 R8", "header", {hdrBar, hdrData}, eh);
        end
      end
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) chk(1'b0, "R10 R11", "unexpected payload", {55'h0, outData, outBe, outLast}, '0);
        else begin
          logic [74:0] ep;
          string rq;
          ep = expQ.pop_front();
          rq = (ep[74:73] == 2'd2) ? "R7" : ((ep[74:73] == 2'd1) ? "R6 R4" : "R5 R4");
          chk({outData, outBe, outLast} == ep[72:0], rq, "payload beat",
              {63'h0, outData, outBe, outLast}, {63'h0, ep[72:0]});
          chk(hdrBar == curBar, "R8", "bar during payload", {128'h0, hdrBar}, {128'h0, curBar});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [63:0] heldData;
    logic [7:0]  heldBe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(inReady === 1'b1, "R1", "inReady after reset", {135'h0, inReady}, 136'h1);
    chk(outValid === 1'b0, "R1", "outValid after reset", {135'h0, outValid}, 136'h0);
    chk(hdrValid === 1'b0, "R1", "hdrValid after reset", {135'h0, hdrValid}, 136'h0);

    // Table-driven traffic with random gaps and output stalls.
    for (int p = 0; p < 9; p++) buildPkt(p, PKT_TAB[p]);
    while (!(txQ.size() == 0 && expQ.size() == 0 && hdrQ.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);

    // Directed: output held off while a long packet floods the buffer (R2, R9).
    forceStall = 1'b1;
    noGaps = 1'b1;
    buildPkt(9, {1'b0, 1'b1, 1'b0, 5'd12, 8'h33});
    while (txQ.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    #2;
    chk(inReady === 1'b0, "R2", "inReady with full buffer", {135'h0, inReady}, 136'h0);
    chk(outValid === 1'b1, "R9", "outValid while stalled", {135'h0, outValid}, 136'h1);
    heldData = outData; heldBe = outBe;
    repeat (3) @(negedge clk);
    #2;
    chk(outData == heldData && outBe == heldBe, "R9", "held beat stable",
        {64'h0, outData, outBe}, {64'h0, heldData, heldBe});
    forceStall = 1'b0;
    while (!(expQ.size() == 0 && hdrQ.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    chk(inReady === 1'b1, "R2", "inReady after drain", {135'h0, inReady}, 136'h1);
    chk(outValid === 1'b0, "R10", "no payload when idle", {135'h0, outValid}, 136'h0);
    finishRun();
  end
endmodule